// File: doc/BRIEF.md
# Barker Acquisition Threshold Detector

This block finds the code phase of an 11-chip Barker spreading sequence in a stream of coarsely quantized received samples. Every accepted sample enters an 11-deep delay line. The whole window is then correlated against the stored chip pattern, and the result is reported as a signed sum. A magnitude comparison against a symmetric threshold raises a one-cycle detection flag.

There are two thresholding modes. In fixed mode the threshold is a constant ±24. In adaptive mode the threshold normally sits at ±36. A chip counter watches for a full code period (11 accepted samples) with no detection. When that happens the threshold falls to zero, so the very next sample is declared a peak. Any detection, and reset, put the threshold back to ±36 and clear the counter.

The block is intended for the front of a spread-spectrum receiver, before despreading. The current threshold is available as an output so downstream logic can tell which regime a detection came from.

Top module: `barker_acq_detector`

## Requirements
- R1: Sample decoding is sign-magnitude. `sample_i[2]` set means negative, and `sample_i[1:0]` plus one gives the magnitude. Code 3'b000 is +1, 3'b011 is +4, 3'b100 is -1 and 3'b111 is -4.
- R2: A sample is accepted only on a cycle with `sample_valid_i` high. On cycles without a valid sample, `corr_o` and the delay line hold their values.
- R3: `corr_o` is the sum of the 11 stored samples, each multiplied by its chip. The chip sequence is +1 +1 +1 -1 -1 -1 +1 -1 -1 +1 -1. Chip 0 pairs with the oldest stored sample and chip 10 with the newest. Entries not yet filled since reset count as zero. The value always lies within ±44.
- R4: `corr_o` and `sync_o` are registered and both update on the clock edge that accepts the sample. `sync_o` is high for that one cycle when the new correlation magnitude is at least the effective threshold. `sync_o` is low on every cycle that follows a cycle without a valid sample.
- R5: With `adaptive_i` low, the effective threshold is 24 and `threshold_o` reads 24. The chip counter is held clear and the adaptive threshold is held at 36.
- R6: With `adaptive_i` high, the threshold starts at 36. Each accepted sample without a detection advances the chip counter. On the 11th such sample in a row, the threshold becomes 0 and the counter clears.
- R7: A detection clears the counter and restores the threshold to 36. This takes priority when it falls on the same sample as the 11th count. With the threshold at 0, the next accepted sample always produces a detection, because the sum of 11 odd values is never zero.
- R8: While `rst_ni` is low, the delay line is all zero, `corr_o` is 0, `sync_o` is 0, the counter is clear and the adaptive threshold is 36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | 3 | Sign-magnitude sample code |
| adaptive_i | input | 1 | 1: adaptive threshold, 0: fixed threshold |
| corr_o | output | 7 | Signed correlation of the current window |
| sync_o | output | 1 | Detection flag, one cycle per qualifying sample |
| threshold_o | output | 6 | Effective threshold magnitude |

## Verification
Two events can fall on the same accepted sample: the 11th non-detecting count that would drop the threshold, and a detection. The bench provokes this straight after reset by sending a fully aligned sequence of magnitude-4 samples. The 11th sample then yields +44 at the exact moment the counter completes. The expected outcome is that `sync_o` rises and the threshold stays at 36 rather than falling to 0. A behavioural model compares all three outputs on every clock through long runs of random samples, valid gaps and mode changes.

// File: rtl/barker_acq_pkg.sv
package barker_acq_pkg;
  localparam int DEF_TAPS   = 11;
  localparam int DEF_SAMP_W = 3;
  // bit i = chip i, 1 -> +1, 0 -> -1; chip 0 meets the oldest sample
  localparam logic [DEF_TAPS-1:0] DEF_CHIPS = 11'b010_0100_0111;
  localparam int DEF_THR_STRONG = 36;
  localparam int DEF_THR_FIXED  = 24;
endpackage

// File: rtl/barker_sample_line.sv
module barker_sample_line #(
  parameter int TAPS   = 11,
  parameter int SAMP_W = 3,
  localparam int VAL_W = SAMP_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [SAMP_W-1:0]           sample_i,
  output logic [TAPS-1:0][VAL_W-1:0]  win_nxt_o
);
  logic [TAPS-1:0][VAL_W-1:0] win_q;
  logic [VAL_W-1:0]           mag;
  logic [VAL_W-1:0]           val;

  assign mag = VAL_W'(sample_i[SAMP_W-2:0]) + VAL_W'(1);
  assign val = sample_i[SAMP_W-1] ? (~mag + VAL_W'(1)) : mag;

  // index 0 is the newest sample
  always_comb begin
    win_nxt_o = win_q;
    if (valid_i) win_nxt_o = {win_q[TAPS-2:0], val};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_nxt_o;
  end
endmodule

// File: rtl/barker_correlator.sv
module barker_correlator #(
  parameter int              TAPS   = 11,
  parameter int              VAL_W  = 4,
  parameter int              CORR_W = 7,
  parameter logic [TAPS-1:0] CHIPS  = '1
) (
  input  logic [TAPS-1:0][VAL_W-1:0] win_i,
  output logic [CORR_W-1:0]          corr_o
);
  logic [TAPS-1:0][CORR_W-1:0] term;

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    logic [CORR_W-1:0] ext;
    assign ext = {{(CORR_W-VAL_W){win_i[j][VAL_W-1]}}, win_i[j]};
    // window slot j holds chip TAPS-1-j
    if (CHIPS[TAPS-1-j]) begin : g_pos
      assign term[j] = ext;
    end else begin : g_neg
      assign term[j] = ~ext + CORR_W'(1);
    end
  end

  always_comb begin
    corr_o = '0;
    for (int j = 0; j < TAPS; j++) corr_o = corr_o + term[j];
  end
endmodule

// File: rtl/barker_threshold_ctrl.sv
module barker_threshold_ctrl #(
  parameter int TAPS       = 11,
  parameter int CORR_W     = 7,
  parameter int THR_W      = 6,
  parameter int THR_STRONG = 36,
  parameter int THR_FIXED  = 24,
  localparam int CNT_W     = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              adaptive_i,
  input  logic [CORR_W-1:0] corr_nxt_i,
  output logic [CORR_W-1:0] corr_o,
  output logic              sync_o,
  output logic [THR_W-1:0]  threshold_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [THR_W-1:0]  thr_q;
  logic [CORR_W-1:0] mag;
  logic              hit;

  assign threshold_o = adaptive_i ? thr_q : THR_W'(THR_FIXED);
  assign mag = corr_nxt_i[CORR_W-1] ? (~corr_nxt_i + CORR_W'(1)) : corr_nxt_i;
  assign hit = mag >= CORR_W'(threshold_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_o <= '0;
      sync_o <= 1'b0;
      cnt_q  <= '0;
      thr_q  <= THR_W'(THR_STRONG);
    end else begin
      sync_o <= valid_i && hit;
      if (valid_i) corr_o <= corr_nxt_i;
      if (!adaptive_i) begin
        cnt_q <= '0;
        thr_q <= THR_W'(THR_STRONG);
      end else if (valid_i) begin
        if (hit) begin                       // detection wins over period end
          cnt_q <= '0;
          thr_q <= THR_W'(THR_STRONG);
        end else if (cnt_q == CNT_W'(TAPS-1)) begin
          cnt_q <= '0;
          thr_q <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/barker_acq_detector.sv
module barker_acq_detector
  import barker_acq_pkg::*;
#(
  parameter int              TAPS       = DEF_TAPS,
  parameter int              SAMP_W     = DEF_SAMP_W,
  parameter logic [TAPS-1:0] CHIPS      = DEF_CHIPS,
  parameter int              THR_STRONG = DEF_THR_STRONG,
  parameter int              THR_FIXED  = DEF_THR_FIXED,
  localparam int VAL_W  = SAMP_W + 1,
  localparam int PEAK   = TAPS * (2 ** (SAMP_W - 1)),
  localparam int THR_W  = $clog2(PEAK + 1),
  localparam int CORR_W = THR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [SAMP_W-1:0] sample_i,
  input  logic              adaptive_i,
  output logic [CORR_W-1:0] corr_o,
  output logic              sync_o,
  output logic [THR_W-1:0]  threshold_o
);
  logic [TAPS-1:0][VAL_W-1:0] win_nxt;
  logic [CORR_W-1:0]          corr_nxt;

  barker_sample_line #(.TAPS(TAPS), .SAMP_W(SAMP_W)) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (sample_valid_i),
    .sample_i  (sample_i),
    .win_nxt_o (win_nxt)
  );

  barker_correlator #(.TAPS(TAPS), .VAL_W(VAL_W), .CORR_W(CORR_W), .CHIPS(CHIPS)) u_corr (
    .win_i  (win_nxt),
    .corr_o (corr_nxt)
  );

  barker_threshold_ctrl #(
    .TAPS(TAPS), .CORR_W(CORR_W), .THR_W(THR_W),
    .THR_STRONG(THR_STRONG), .THR_FIXED(THR_FIXED)
  ) u_thr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (sample_valid_i),
    .adaptive_i  (adaptive_i),
    .corr_nxt_i  (corr_nxt),
    .corr_o      (corr_o),
    .sync_o      (sync_o),
    .threshold_o (threshold_o)
  );
endmodule

// File: rtl/barker_acq_detector_chk.sv
module barker_acq_detector_chk #(
  parameter int CORR_W     = 7,
  parameter int THR_W      = 6,
  parameter int PEAK       = 44,
  parameter int THR_STRONG = 36,
  parameter int THR_FIXED  = 24
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sample_valid_i,
  input logic [2:0]               sample_i,
  input logic                     adaptive_i,
  input logic signed [CORR_W-1:0] corr_o,
  input logic                     sync_o,
  input logic [THR_W-1:0]         threshold_o
);
  assert_corr_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_o <= PEAK) && (corr_o >= -PEAK));

  assert_corr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(corr_o));

  assert_sync_needs_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> $past(sample_valid_i));

  assert_fixed_thr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adaptive_i |-> threshold_o == THR_W'(THR_FIXED));

  assert_fixed_peak_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && !$past(adaptive_i)) |-> (corr_o >= THR_FIXED || corr_o <= -THR_FIXED));

  assert_adapt_levels_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adaptive_i |-> (threshold_o == THR_W'(THR_STRONG) || threshold_o == '0));

  assert_zero_recovers_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adaptive_i && $past(adaptive_i) && $past(sample_valid_i) && $past(threshold_o) == '0)
      |-> (sync_o && threshold_o == THR_W'(THR_STRONG)));
endmodule

bind barker_acq_detector barker_acq_detector_chk #(
  .CORR_W(CORR_W), .THR_W(THR_W), .PEAK(PEAK),
  .THR_STRONG(THR_STRONG), .THR_FIXED(THR_FIXED)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .sample_i       (sample_i),
  .adaptive_i     (adaptive_i),
  .corr_o         (corr_o),
  .sync_o         (sync_o),
  .threshold_o    (threshold_o)
);

// File: tb/barker_acq_detector_tb.sv
module barker_acq_detector_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [2:0] smp = 3'b000;
  logic       adp = 1'b1;
  logic signed [6:0] corr;
  logic       sync;
  logic [5:0] thr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  barker_acq_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(vld), .sample_i(smp),
    .adaptive_i(adp), .corr_o(corr), .sync_o(sync), .threshold_o(thr_o)
  );

  // behavioural reference
  int chip[11] = '{1, 1, 1, -1, -1, -1, 1, -1, -1, 1, -1};
  int win[$];
  int m_thr, m_cnt, m_corr;
  bit m_sync;

  function automatic int dec(logic [2:0] c);
    int m = int'(c[1:0]) + 1;
    return c[2] ? -m : m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win.delete(); m_thr = 36; m_cnt = 0; m_corr = 0; m_sync = 0;
    end else if (vld) begin
      int c, eff;
      bit hit;
      win.push_front(dec(smp));
      if (win.size() > 11) void'(win.pop_back());
      c = 0;
      foreach (win[i]) c += win[i] * chip[10 - i];
      m_corr = c;
      eff = adp ? m_thr : 24;
      hit = ((c < 0) ? -c : c) >= eff;
      m_sync = hit;
      if (!adp || hit) begin m_thr = 36; m_cnt = 0; end
      else if (m_cnt == 10) begin m_thr = 0; m_cnt = 0; end
      else m_cnt++;
    end else begin
      m_sync = 0;
      if (!adp) begin m_thr = 36; m_cnt = 0; end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 corr", int'(corr), m_corr);
      chk("R4 sync", int'(sync), int'(m_sync));
      chk("R6 threshold", int'(thr_o), adp ? m_thr : 24);
    end
  end

  task automatic push(logic [2:0] s);
    @(posedge clk); #1; vld = 1'b1; smp = s;
  endtask
  task automatic gap();
    @(posedge clk); #1; vld = 1'b0;
  endtask
  task automatic do_reset();
    @(posedge clk); #1; rst_n = 1'b0; vld = 1'b0;
    @(negedge clk);
    chk("R8 corr", int'(corr), 0);
    chk("R8 sync", int'(sync), 0);
    chk("R8 thr", int'(thr_o), adp ? 36 : 24);
    @(posedge clk); #1; rst_n = 1'b1;
  endtask
  // aligned sequence, chip 0 first, given magnitude code bits
  task automatic aligned(logic [1:0] m);
    for (int k = 0; k < 11; k++) push({(chip[k] < 0), m});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    adp = 1'b1;
    do_reset();

    // R1: single sample meets chip 10 (-1)
    push(3'b000); gap(); @(negedge clk);
    chk("R1 +1 code", int'(corr), -1);
    push(3'b111); gap(); @(negedge clk);
    chk("R1 -4 code", int'(corr), 4 + 1);
    // R2: idle cycles keep corr
    gap(); gap(); @(negedge clk);
    chk("R2 hold", int'(corr), 5);

    // R7: full peak lands on the 11th count after reset
    do_reset();
    aligned(2'b11); gap(); @(negedge clk);
    chk("R7 collision sync", int'(sync), 1);
    chk("R7 collision thr", int'(thr_o), 36);
    chk("R3 peak", int'(corr), 44);
    @(negedge clk);
    chk("R4 one cycle", int'(sync), 0);

    // R6: eleven weak samples drop the threshold
    do_reset();
    for (int k = 0; k < 11; k++) push(3'b000);
    gap(); @(negedge clk);
    chk("R6 drop", int'(thr_o), 0);
    chk("R6 no sync", int'(sync), 0);
    push(3'b000); gap(); @(negedge clk);
    chk("R7 zero detects", int'(sync), 1);
    chk("R7 restore", int'(thr_o), 36);

    // R5: fixed threshold
    adp = 1'b0;
    do_reset();
    aligned(2'b10); gap(); @(negedge clk);
    chk("R5 mag3 sync", int'(sync), 1);
    chk("R5 thr", int'(thr_o), 24);
    aligned(2'b01); gap(); @(negedge clk);
    chk("R5 mag2 none", int'(sync), 0);

    // random traffic with mode flips and injected peaks
    adp = 1'b1;
    do_reset();
    for (int it = 0; it < 300; it++) begin
      if ($urandom_range(0, 9) == 0) adp = ~adp;
      if ($urandom_range(0, 7) == 0) aligned(2'($urandom_range(1, 3)));
      for (int k = 0; k < 20; k++) begin
        if ($urandom_range(0, 3) == 0) gap();
        else push(3'($urandom));
      end
    end
    gap(); @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule